// File: doc/BRIEF.md
# USB Device Endpoint Handshake Controller

This block holds the control and status words of four USB device endpoints. For every token that the packet engine decodes, it decides how the addressed endpoint answers. The packet engine supplies the endpoint number, the token direction and the payload length. The block returns one registered handshake choice one cycle later: no handshake, NAK, STALL, send data, or ACK. Two flags go with the choice, one marking an isochronous transfer and one asking for a zero-length data packet. When the packet engine reports that a transfer has finished on an endpoint, the block clears that endpoint's arm bit by itself. Software must re-arm the endpoint before the next transfer can proceed.

The block also holds the device address register, which clears on reset and is read/write. It holds the frame number register as well, which captures the frame number of each start-of-frame packet and is read-only. Software reaches all registers through a simple synchronous bus. Read data is registered and appears one cycle after the address. Line coding, CRC, bit stuffing and packet buffering belong to other blocks.

Top module: `usb_ep_hs_ctrl`

## Requirements
- R1: After a synchronous reset, every endpoint word, the device address and the frame number read as zero, and resp_valid is 0.
- R2: Register map by byte address. 0x00 is the device address (bits 6:0, read/write). 0x02 is the frame number (bits 10:0, writes have no effect). Endpoint n sits at 0x08+2n. Endpoint bits are: bit0 arm, bit1 enable, bit2 direction (1 = IN), bit3 isochronous, bit4 stall, bit5 zero-length. All other bits read as 0. bus_rdata shows the register addressed in the previous cycle.
- R3: A token to an endpoint with enable = 0 gets code 0 (no handshake) with both flags low.
- R4: A token to an enabled endpoint with stall = 1 gets code 2 (STALL), whatever the arm bit holds. The stall bit stays set until software clears it.
- R5: A token to an enabled endpoint that is not stalled, whose direction (tok_in) differs from the direction bit, gets code 2 (STALL).
- R6: An enabled endpoint that is not isochronous and not armed answers a matching token with code 1 (NAK).
- R7: An armed endpoint that is not isochronous answers IN with code 3 (data) and OUT with code 4 (ACK). resp_zlp equals the zero-length bit on an IN data answer and is 0 otherwise.
- R8: An isochronous endpoint never handshakes. Armed IN gives code 3 with resp_iso = 1. Armed OUT gives code 0 with resp_iso = 1. An isochronous endpoint that is not armed gives code 0 with resp_iso = 0.
- R9: Payload limits: a non-isochronous armed endpoint with tok_len > 64 answers code 2. An isochronous armed endpoint with tok_len > 1024 answers code 0 with both flags low.
- R10: xfer_done clears the arm bit of endpoint xfer_ep only. When a bus write to that endpoint happens in the same cycle, the arm bit ends up 0 and the other bits take the written value.
- R11: sof_valid loads sof_frame into the frame number register.
- R12: resp_valid is high exactly in the cycle after tok_valid. The answer reflects the endpoint word as it stood in the token cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| tok_valid | input | 1 | Decoded token strobe |
| tok_ep | input | 2 | Token endpoint number |
| tok_in | input | 1 | Token direction, 1 = IN |
| tok_len | input | 12 | Payload length in bytes |
| xfer_done | input | 1 | Transfer-complete strobe |
| xfer_ep | input | 2 | Endpoint whose transfer completed |
| sof_valid | input | 1 | Start-of-frame strobe |
| sof_frame | input | 11 | Frame number carried by the SOF |
| resp_valid | output | 1 | Handshake decision valid |
| resp_code | output | 3 | 0 none, 1 NAK, 2 STALL, 3 data, 4 ACK |
| resp_iso | output | 1 | Isochronous transfer accepted |
| resp_zlp | output | 1 | Send a zero-length data packet |
| dev_addr | output | 7 | Current device address |

## Verification
Directed cases walk one endpoint through each rung of the answer priority: disabled, stalled with arm set, wrong direction, unarmed, armed IN with and without zero-length, and armed OUT. Each case isolates a single decision from the one above it. Lengths of 64, 65, 1024 and 1025 separate the bulk limit from the isochronous limit. A simultaneous write and transfer-complete shows that only the arm bit yields to hardware. Random endpoint words, token directions and lengths, mixed with transfer-complete strobes on random endpoints, then test the priority order and the per-endpoint isolation of the arm clear against a reference model.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int CTL_W   = 6;
  localparam int B_ARM   = 0;
  localparam int B_EN    = 1;
  localparam int B_DIR   = 2;
  localparam int B_ISO   = 3;
  localparam int B_STALL = 4;
  localparam int B_ZLP   = 5;

  typedef enum logic [2:0] {
    HS_NONE  = 3'd0,
    HS_NAK   = 3'd1,
    HS_STALL = 3'd2,
    HS_DATA  = 3'd3,
    HS_ACK   = 3'd4
  } hs_code_e;
endpackage

// File: rtl/usb_ep_csr_bank.sv
module usb_ep_csr_bank
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP  = 4,
  parameter int AW      = 5,
  parameter int DATA_W  = 16,
  parameter int EP_BASE = 8,
  localparam int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic [AW-1:0]            bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     xfer_done,
  input  logic [EP_W-1:0]          xfer_ep,
  output logic [NUM_EP*CTL_W-1:0]  ctl_flat
);
  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    localparam logic [AW-1:0] MY_ADDR = AW'(EP_BASE + 2*i);
    logic [CTL_W-1:0] ctl_q;
    logic             wr_hit;
    logic             clr_hit;

    assign wr_hit  = bus_wr && (bus_addr == MY_ADDR);
    assign clr_hit = xfer_done && (xfer_ep == EP_W'(i));

    // later assignment to the arm bit gives hardware clear priority
    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q <= '0;
      end else begin
        if (wr_hit)  ctl_q <= bus_wdata[CTL_W-1:0];
        if (clr_hit) ctl_q[B_ARM] <= 1'b0;
      end
    end

    assign ctl_flat[i*CTL_W +: CTL_W] = ctl_q;
  end
endmodule

// File: rtl/usb_ep_dev_regs.sv
module usb_ep_dev_regs #(
  parameter int AW        = 5,
  parameter int DATA_W    = 16,
  parameter int DEVADDR_W = 7,
  parameter int FRAME_W   = 11,
  parameter int ADDR_REG  = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 sof_valid,
  input  logic [FRAME_W-1:0]   sof_frame,
  output logic [DEVADDR_W-1:0] dev_addr_q,
  output logic [FRAME_W-1:0]   frame_q
);
  localparam logic [AW-1:0] DEV_A = AW'(ADDR_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_addr_q <= '0;
    end else if (bus_wr && bus_addr == DEV_A) begin
      dev_addr_q <= bus_wdata[DEVADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
    end else if (sof_valid) begin
      frame_q <= sof_frame;
    end
  end
endmodule

// File: rtl/usb_ep_hs_decide.sv
module usb_ep_hs_decide
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP    = 4,
  parameter int LEN_W     = 12,
  parameter int MAX_BULK  = 64,
  parameter int MAX_ISO   = 1024,
  localparam int EP_W     = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_EP*CTL_W-1:0] ctl_flat,
  input  logic                    tok_valid,
  input  logic [EP_W-1:0]         tok_ep,
  input  logic                    tok_in,
  input  logic [LEN_W-1:0]        tok_len,
  output logic                    resp_valid,
  output logic [2:0]              resp_code,
  output logic                    resp_iso,
  output logic                    resp_zlp
);
  localparam logic [LEN_W-1:0] LIM_BULK = LEN_W'(MAX_BULK);
  localparam logic [LEN_W-1:0] LIM_ISO  = LEN_W'(MAX_ISO);

  logic [CTL_W-1:0] ctl_a [NUM_EP];
  logic [CTL_W-1:0] cur;
  hs_code_e         code_d;
  logic             iso_d;
  logic             zlp_d;

  always_comb begin
    for (int i = 0; i < NUM_EP; i++) ctl_a[i] = ctl_flat[i*CTL_W +: CTL_W];
  end

  assign cur = ctl_a[tok_ep];

  always_comb begin
    code_d = HS_NONE;
    iso_d  = 1'b0;
    zlp_d  = 1'b0;
    if (!cur[B_EN]) begin
      code_d = HS_NONE;
    end else if (cur[B_STALL] || (cur[B_DIR] != tok_in)) begin
      code_d = HS_STALL;
    end else if (cur[B_ISO]) begin
      if (cur[B_ARM] && tok_len <= LIM_ISO) begin
        iso_d  = 1'b1;
        code_d = tok_in ? HS_DATA : HS_NONE;
        zlp_d  = tok_in && cur[B_ZLP];
      end
    end else if (!cur[B_ARM]) begin
      code_d = HS_NAK;
    end else if (tok_len > LIM_BULK) begin
      code_d = HS_STALL;
    end else if (tok_in) begin
      code_d = HS_DATA;
      zlp_d  = cur[B_ZLP];
    end else begin
      code_d = HS_ACK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_code  <= HS_NONE;
      resp_iso   <= 1'b0;
      resp_zlp   <= 1'b0;
    end else begin
      resp_valid <= tok_valid;
      resp_code  <= tok_valid ? code_d : HS_NONE;
      resp_iso   <= tok_valid && iso_d;
      resp_zlp   <= tok_valid && zlp_d;
    end
  end
endmodule

// File: rtl/usb_ep_hs_ctrl.sv
module usb_ep_hs_ctrl
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP    = 4,
  parameter int AW        = 5,
  parameter int DATA_W    = 16,
  parameter int LEN_W     = 12,
  parameter int FRAME_W   = 11,
  parameter int DEVADDR_W = 7,
  parameter int MAX_BULK  = 64,
  parameter int MAX_ISO   = 1024,
  parameter int ADDR_REG  = 0,
  parameter int FRAME_REG = 2,
  parameter int EP_BASE   = 8,
  localparam int EP_W     = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 tok_valid,
  input  logic [EP_W-1:0]      tok_ep,
  input  logic                 tok_in,
  input  logic [LEN_W-1:0]     tok_len,
  input  logic                 xfer_done,
  input  logic [EP_W-1:0]      xfer_ep,
  input  logic                 sof_valid,
  input  logic [FRAME_W-1:0]   sof_frame,
  output logic                 resp_valid,
  output logic [2:0]           resp_code,
  output logic                 resp_iso,
  output logic                 resp_zlp,
  output logic [DEVADDR_W-1:0] dev_addr
);
  localparam logic [AW-1:0] FRM_A = AW'(FRAME_REG);
  localparam logic [AW-1:0] DEV_A = AW'(ADDR_REG);

  logic [NUM_EP*CTL_W-1:0] ctl_flat;
  logic [FRAME_W-1:0]      frame_q;
  logic [DEVADDR_W-1:0]    dev_addr_q;
  logic [DATA_W-1:0]       rd_mux;

  usb_ep_csr_bank #(
    .NUM_EP(NUM_EP), .AW(AW), .DATA_W(DATA_W), .EP_BASE(EP_BASE)
  ) u_csr (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .xfer_done(xfer_done), .xfer_ep(xfer_ep),
    .ctl_flat(ctl_flat)
  );

  usb_ep_dev_regs #(
    .AW(AW), .DATA_W(DATA_W), .DEVADDR_W(DEVADDR_W), .FRAME_W(FRAME_W),
    .ADDR_REG(ADDR_REG)
  ) u_dev (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .sof_valid(sof_valid), .sof_frame(sof_frame),
    .dev_addr_q(dev_addr_q), .frame_q(frame_q)
  );

  usb_ep_hs_decide #(
    .NUM_EP(NUM_EP), .LEN_W(LEN_W), .MAX_BULK(MAX_BULK), .MAX_ISO(MAX_ISO)
  ) u_dec (
    .clk(clk), .rst(rst), .ctl_flat(ctl_flat), .tok_valid(tok_valid),
    .tok_ep(tok_ep), .tok_in(tok_in), .tok_len(tok_len),
    .resp_valid(resp_valid), .resp_code(resp_code),
    .resp_iso(resp_iso), .resp_zlp(resp_zlp)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == DEV_A) rd_mux[DEVADDR_W-1:0] = dev_addr_q;
    if (bus_addr == FRM_A) rd_mux[FRAME_W-1:0]   = frame_q;
    for (int i = 0; i < NUM_EP; i++) begin
      if (bus_addr == AW'(EP_BASE + 2*i))
        rd_mux[CTL_W-1:0] = ctl_flat[i*CTL_W +: CTL_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign dev_addr = dev_addr_q;
endmodule

// File: rtl/usb_ep_hs_chk.sv
module usb_ep_hs_chk
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP  = 4,
  parameter int FRAME_W = 11,
  localparam int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tok_valid,
  input logic [EP_W-1:0]         tok_ep,
  input logic                    tok_in,
  input logic                    xfer_done,
  input logic [EP_W-1:0]         xfer_ep,
  input logic                    sof_valid,
  input logic [FRAME_W-1:0]      sof_frame,
  input logic [FRAME_W-1:0]      frame_q,
  input logic [NUM_EP*CTL_W-1:0] ctl_flat,
  input logic                    resp_valid,
  input logic [2:0]              resp_code,
  input logic                    resp_iso
);
  logic [CTL_W-1:0] ctl_a [NUM_EP];
  logic [CTL_W-1:0] cur;
  logic             xd_q;
  logic [EP_W-1:0]  xe_q;

  always_comb begin
    for (int i = 0; i < NUM_EP; i++) ctl_a[i] = ctl_flat[i*CTL_W +: CTL_W];
  end
  assign cur = ctl_a[tok_ep];

  always_ff @(posedge clk) begin
    if (rst) begin
      xd_q <= 1'b0;
      xe_q <= '0;
    end else begin
      xd_q <= xfer_done;
      xe_q <= xfer_ep;
    end
  end

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    tok_valid && !cur[B_EN] |=> resp_valid && resp_code == 3'd0);

  // R4
  stall_first_chk: assert property (@(posedge clk) disable iff (rst)
    tok_valid && cur[B_EN] && cur[B_STALL] |=> resp_code == 3'd2);

  // R6
  unarmed_nak_chk: assert property (@(posedge clk) disable iff (rst)
    tok_valid && cur[B_EN] && !cur[B_STALL] && (cur[B_DIR] == tok_in)
    && !cur[B_ISO] && !cur[B_ARM] |=> resp_code == 3'd1);

  // R8
  iso_no_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_iso |-> (resp_code == 3'd0 || resp_code == 3'd3));

  // R10
  arm_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    xd_q |-> !ctl_a[xe_q][B_ARM]);

  // R11
  frame_load_chk: assert property (@(posedge clk) disable iff (rst)
    sof_valid |=> frame_q == $past(sof_frame));

  // R12
  resp_follows_tok_chk: assert property (@(posedge clk) disable iff (rst)
    tok_valid |=> resp_valid);

  // R12
  resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tok_valid |=> !resp_valid);
endmodule

bind usb_ep_hs_ctrl usb_ep_hs_chk #(.NUM_EP(NUM_EP), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst(rst), .tok_valid(tok_valid), .tok_ep(tok_ep),
  .tok_in(tok_in), .xfer_done(xfer_done), .xfer_ep(xfer_ep),
  .sof_valid(sof_valid), .sof_frame(sof_frame), .frame_q(frame_q),
  .ctl_flat(ctl_flat), .resp_valid(resp_valid), .resp_code(resp_code),
  .resp_iso(resp_iso)
);

// File: tb/usb_ep_hs_ctrl_test.sv
module usb_ep_hs_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tok_valid = 1'b0;
  logic [1:0]  tok_ep = '0;
  logic        tok_in = 1'b0;
  logic [11:0] tok_len = '0;
  logic        xfer_done = 1'b0;
  logic [1:0]  xfer_ep = '0;
  logic        sof_valid = 1'b0;
  logic [10:0] sof_frame = '0;
  logic        resp_valid;
  logic [2:0]  resp_code;
  logic        resp_iso;
  logic        resp_zlp;
  logic [6:0]  dev_addr;

  int errors = 0;
  int checks = 0;
  logic [5:0] model [4];

  always #2.5 clk = ~clk;

  usb_ep_hs_ctrl uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tok_valid(tok_valid),
    .tok_ep(tok_ep), .tok_in(tok_in), .tok_len(tok_len),
    .xfer_done(xfer_done), .xfer_ep(xfer_ep), .sof_valid(sof_valid),
    .sof_frame(sof_frame), .resp_valid(resp_valid), .resp_code(resp_code),
    .resp_iso(resp_iso), .resp_zlp(resp_zlp), .dev_addr(dev_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {code[2:0], iso, zlp} from the requirement rules
  function automatic logic [4:0] exp_resp(input logic [5:0] c, input logic tin, input int len);
    if (!c[1])                 return {3'd0, 2'b00};   // R3
    if (c[4])                  return {3'd2, 2'b00};   // R4
    if (c[2] != tin)           return {3'd2, 2'b00};   // R5
    if (c[3]) begin                                    // R8
      if (!c[0] || len > 1024) return {3'd0, 2'b00};
      if (tin)                 return {3'd3, 1'b1, c[5]};
      return {3'd0, 2'b10};
    end
    if (!c[0])                 return {3'd1, 2'b00};   // R6
    if (len > 64)              return {3'd2, 2'b00};   // R9
    if (tin)                   return {3'd3, 1'b0, c[5]}; // R7
    return {3'd4, 2'b00};
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a >= 5'd8 && a < 5'd16 && !a[0]) model[(a - 5'd8) >> 1] = d[5:0];
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic done(input logic [1:0] e);
    @(negedge clk);
    xfer_done = 1'b1; xfer_ep = e;
    @(negedge clk);
    xfer_done = 1'b0;
    model[e][0] = 1'b0;
  endtask

  task automatic tok(input string req, input logic [1:0] e, input logic tin, input int len);
    logic [4:0] ex;
    ex = exp_resp(model[e], tin, len);
    @(negedge clk);
    tok_valid = 1'b1; tok_ep = e; tok_in = tin; tok_len = 12'(len);
    @(negedge clk);
    tok_valid = 1'b0;
    check({req, " R12 valid"}, 32'(resp_valid), 32'd1);
    check(req, {27'd0, resp_code, resp_iso, resp_zlp}, {27'd0, ex});
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    int unsigned seed;
    for (int i = 0; i < 4; i++) model[i] = '0;
    seed = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(5'h00, r); check("R1 devaddr", 32'(r), 0);
    rd(5'h02, r); check("R1 frame", 32'(r), 0);
    for (int i = 0; i < 4; i++) begin
      rd(5'(8 + 2*i), r); check("R1 ep", 32'(r), 0);
    end
    check("R1 resp_valid", 32'(resp_valid), 0);

    // R2 map, widths, read-only frame
    wr(5'h00, 16'hFFFF);
    rd(5'h00, r); check("R2 devaddr width", 32'(r), 32'h7F);
    check("R2 dev_addr port", 32'(dev_addr), 32'h7F);
    wr(5'h0C, 16'hFFFF);
    rd(5'h0C, r); check("R2 ep2 upper zero", 32'(r), 32'h3F);
    rd(5'h0A, r); check("R2 ep1 untouched", 32'(r), 0);
    wr(5'h02, 16'h07FF);
    rd(5'h02, r); check("R2 frame write ignored", 32'(r), 0);

    // R11 SOF capture
    @(negedge clk); sof_valid = 1'b1; sof_frame = 11'h5A3;
    @(negedge clk); sof_valid = 1'b0;
    rd(5'h02, r); check("R11 frame", 32'(r), 32'h5A3);

    // directed priority walk on ep1 (bits: arm0 en1 dir2 iso3 stall4 zlp5)
    wr(5'h0A, 16'h0005); tok("R3 disabled", 2'd1, 1'b1, 8);
    wr(5'h0A, 16'h0017); tok("R4 stall over arm", 2'd1, 1'b1, 8);
    rd(5'h0A, r); check("R4 stall sticky", 32'(r), 32'h17);
    wr(5'h0A, 16'h0007); tok("R5 dir mismatch", 2'd1, 1'b0, 8);
    wr(5'h0A, 16'h0006); tok("R6 nak", 2'd1, 1'b1, 8);
    wr(5'h0A, 16'h0027); tok("R7 in zlp", 2'd1, 1'b1, 0);
    wr(5'h0A, 16'h0003); tok("R7 out ack", 2'd1, 1'b0, 64);
    tok("R9 bulk over", 2'd1, 1'b0, 65);
    wr(5'h0A, 16'h000F); tok("R8 iso in", 2'd1, 1'b1, 1024);
    tok("R9 iso over", 2'd1, 1'b1, 1025);
    wr(5'h0A, 16'h000B); tok("R8 iso out", 2'd1, 1'b0, 512);
    wr(5'h0A, 16'h000A); tok("R8 iso unarmed", 2'd1, 1'b0, 16);

    // R10 clear only target ep
    wr(5'h08, 16'h0003); wr(5'h0E, 16'h0007);
    done(2'd3);
    rd(5'h0E, r); check("R10 ep3 arm cleared", 32'(r), 32'h06);
    rd(5'h08, r); check("R10 ep0 untouched", 32'(r), 32'h03);

    // R10 write and hardware clear in same cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'h0C; bus_wdata = 16'h0023;
    xfer_done = 1'b1; xfer_ep = 2'd2;
    @(negedge clk);
    bus_wr = 1'b0; xfer_done = 1'b0;
    model[2] = 6'h22;
    rd(5'h0C, r); check("R10 collision", 32'(r), 32'h22);

    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [1:0] e;
      int len;
      int sel;
      e = 2'($urandom);
      wr(5'(8 + 2*int'(e)), 16'($urandom));
      if ($urandom_range(0, 3) == 0) done(2'($urandom));
      sel = $urandom_range(0, 5);
      case (sel)
        0: len = 64;
        1: len = 65;
        2: len = 1024;
        3: len = 1025;
        4: len = 0;
        default: len = $urandom_range(0, 2047);
      endcase
      tok("R7/R8/R9 random", 2'($urandom), 1'($urandom), len);
    end
    for (int i = 0; i < 4; i++) begin
      rd(5'(8 + 2*i), r); check("R10 final ep state", 32'(r), 32'(model[i]));
    end
    finish_run();
  end
endmodule